// File: doc/BRIEF.md
# 8-bit Timer/Counter with Compare-Driven Waveform Output

An 8-bit up-counter advances once per pulse from an internal prescaler. The prescaler can stop the counter or divide the system clock by 1, 8, 64, 256 or 1024. A host reaches the count, the compare value, a control byte and a flag byte through a small synchronous register port.

Each time the count advances, it is compared with the compare value. Three counting modes are supported:

- **Free-running:** the counter simply counts and wraps.
- **Clear on compare:** the counter returns to zero when it matches the compare value.
- **Single-slope fast PWM:** the counter runs the full 0x00 to 0xFF ramp.

A per-mode output action drives a waveform level from the compare and wrap events. That level reaches the pin only when the host has enabled the pin driver. Two sticky flags record counter wrap and compare match, and the host clears each one by writing 1 to it.

Typical uses are a periodic event source, a square-wave generator whose frequency is set by the compare value, and a fixed-frequency PWM source whose duty cycle is set by the compare value.

Top module: `tmr8_wavegen`

## Requirements
- R1: Register map: address 0 is the count, 1 the compare value, 2 the control byte and 3 the flags. Control bits [2:0] are the prescale select, [4:3] the mode (0 free-running, 1 clear on compare, 2 fast PWM, 3 acts as 0), [6:5] the output action (0 off, 1 toggle, 2 clear/non-inverting, 3 set/inverting) and bit 7 the pin-drive enable. Flag bit 0 is wrap and bit 1 is match. Reads are combinational, and every register resets to 0.
- R2: Prescale select 1..5 advances the counter once every 1, 8, 64, 256 or 1024 clocks. Selects 0, 6 and 7 hold the count.
- R3: In free-running mode the count increments by one per advance and wraps from 0xFF to 0x00.
- R4: The wrap flag sets in the advance that steps the count from 0xFF to 0x00, in every mode. Writing 1 to flag bit 0 clears it.
- R5: The match flag sets on every advance in which the count equals the active compare value. Writing 1 to flag bit 1 clears it.
- R6: A host write to the count overrides the advance in that cycle and suppresses a compare match in that cycle.
- R7: In clear-on-compare mode a match returns the count to 0x00. A written compare value is used from the next cycle on. If that value is below the count, the counter runs to 0xFF, wraps (setting the wrap flag) and only then matches.
- R8: Outside fast PWM, a match toggles, clears or sets the output level for actions 1, 2 and 3. In clear-on-compare mode with toggle and a compare value of 0, the level flips on every advance (half the clock rate with prescale 1).
- R9: In fast PWM, action 2 sets the level at the wrap step and clears it on a match, and action 3 does the opposite. The wrap step takes priority over a match in the same advance, so with action 2 the level is high for compare+1 of every 256 advances.
- R10: In fast PWM the compare value written by the host reads back at once but is used only from the next 0xFF to 0x00 step.
- R11: The drive-enable output equals control bit 7. The pin carries the internal level only when that bit is 1 and the action is connected: not 0, and not 1 in fast PWM. Otherwise the pin is 0, and the internal level is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data (combinational) |
| wave_o | output | 1 | Gated waveform pin |
| wave_oe_o | output | 1 | Pin-drive enable |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The bench targets the following corner cases:

- **Stale compare value in clear-on-compare mode:** a design that compared with `>=` or reloaded late would match early instead of running through 0xFF and raising the wrap flag.
- **Host count write landing on the matching cycle:** a design without the override priority would set the match flag there.
- **Fast PWM with the compare value at 0xFF:** if a match beat the wrap step, the output would not stay high constantly.
- **Mid-period compare change in fast PWM:** an unbuffered design would move the falling edge within the current period.
- **Hidden internal level:** a set action latches the level while the pin driver is off, and the bench then enables the driver. A design that gated the level register itself, rather than the pin, would show 0.

// File: rtl/tmr8_pkg.sv
// Shared types for the 8-bit timer: mode and action encodings, register
// addresses and the control byte layout. Assumes an 8-bit control byte.
package tmr8_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FPWM   = 2'd2,
        MODE_SPARE  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } out_act_e;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CMP   = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic      drive_en;
        out_act_e  act;
        tmr_mode_e mode;
        logic [2:0] psel;
    } ctrl_t;

endpackage

// File: rtl/tmr8_prescaler.sv
// Prescaler: a free-running divider whose low bits, masked per select,
// yield a one-cycle advance pulse. Assumes PRE_W >= 10 so that the
// largest divide (2^10) fits.
module tmr8_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] psel,
    output logic       tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;
    logic             run;
    int unsigned      sh;

    // Free-running divide chain, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Decode the select into a run flag and a log2 divide factor.
    always_comb begin
        run = 1'b1;
        sh  = 0;
        case (psel)
            3'd1:    sh = 0;
            3'd2:    sh = 3;
            3'd3:    sh = 6;
            3'd4:    sh = 8;
            3'd5:    sh = 10;
            default: run = 1'b0;
        endcase
        mask = PRE_W'((32'd1 << sh) - 32'd1);
    end

    // Pulse when all masked divider bits are ones.
    assign tick = run && ((div_q & mask) == mask);

endmodule

// File: rtl/tmr8_counter.sv
// Counter core: holds the count, applies host writes with priority,
// advances on tick and clears on a match in clear-on-compare mode.
// Emits single-cycle match and wrap events.
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic advance;

    // An advance only counts when the host is not writing the count.
    assign advance = tick && !cnt_we;
    assign match_o = advance && (cnt_q == cmp_val);
    assign wrap_o  = advance && (cnt_q == CNT_MAX);

    // Count register: host write first, then match-clear, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wdata;
        end else if (tick) begin
            if (mode == MODE_CTC && match_o) cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr8_cmp_unit.sv
// Compare unit: host-visible compare register plus a shadow copy.
// The shadow is used in fast PWM and reloads only on the wrap step.
// Other modes see the host register directly.
module tmr8_cmp_unit
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode,
    input  logic             wrap,
    input  logic             host_we,
    input  logic [CNT_W-1:0] host_wdata,
    output logic [CNT_W-1:0] host_q,
    output logic [CNT_W-1:0] active_q
);
    logic [CNT_W-1:0] shadow_q;

    // Host compare register, written immediately.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_q <= '0;
        else if (host_we) host_q <= host_wdata;
    end

    // Shadow tracks the host value except in fast PWM between wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)                         shadow_q <= '0;
        else if (mode != MODE_FPWM || wrap) shadow_q <= host_q;
    end

    assign active_q = (mode == MODE_FPWM) ? shadow_q : host_q;

endmodule

// File: rtl/tmr8_wave_unit.sv
// Waveform unit: updates an internal level from match and wrap events
// per mode and action, and gates it onto the pin.
// In fast PWM the wrap step outranks a match in the same advance.
module tmr8_wave_unit
    import tmr8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tmr_mode_e mode,
    input  out_act_e  act,
    input  logic      match,
    input  logic      wrap,
    input  logic      drive_en,
    output logic      level_q,
    output logic      pin_o
);
    logic connected;

    // Internal level update per mode and action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else if (mode == MODE_FPWM) begin
            case (act)
                ACT_CLEAR: begin
                    if (wrap)       level_q <= 1'b1;
                    else if (match) level_q <= 1'b0;
                end
                ACT_SET: begin
                    if (wrap)       level_q <= 1'b0;
                    else if (match) level_q <= 1'b1;
                end
                default: level_q <= level_q;
            endcase
        end else if (match) begin
            case (act)
                ACT_TOGGLE: level_q <= ~level_q;
                ACT_CLEAR:  level_q <= 1'b0;
                ACT_SET:    level_q <= 1'b1;
                default:    level_q <= level_q;
            endcase
        end
    end

    // Pin gate: connected action and drive enable both required.
    assign connected = (act != ACT_OFF) && !(mode == MODE_FPWM && act == ACT_TOGGLE);
    assign pin_o     = drive_en && connected && level_q;

endmodule

// File: rtl/tmr8_wavegen.sv
// Timer top: register port, control byte, sticky flags, and the
// prescaler, counter, compare and waveform units.
// Assumes CNT_W >= 8 so that the control byte fits the data bus.
module tmr8_wavegen
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             wave_o,
    output logic             wave_oe_o,
    output logic             ovf_flag_o,
    output logic             cmp_flag_o
);
    ctrl_t            ctrl_q;
    tmr_mode_e        cur_mode;
    out_act_e         cur_act;
    logic             drive_en;
    logic [2:0]       cur_psel;
    logic             tick;
    logic             cnt_we, cmp_we, ctrl_we, flag_we;
    logic [CNT_W-1:0] cnt_q, cmp_host, cmp_active;
    logic             match, wrap, level_q;
    logic             ovf_q, cmf_q;

    // Register write strobes.
    assign cnt_we  = reg_wr_i && reg_addr_i == ADDR_COUNT;
    assign cmp_we  = reg_wr_i && reg_addr_i == ADDR_CMP;
    assign ctrl_we = reg_wr_i && reg_addr_i == ADDR_CTRL;
    assign flag_we = reg_wr_i && reg_addr_i == ADDR_FLAGS;

    // Control byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end

    assign cur_mode = (ctrl_q.mode == MODE_SPARE) ? MODE_NORMAL : ctrl_q.mode;
    assign cur_act  = ctrl_q.act;
    assign drive_en = ctrl_q.drive_en;
    assign cur_psel = ctrl_q.psel;

    // Sticky flags: an event sets, write-one clears, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            cmf_q <= 1'b0;
        end else begin
            if (wrap)                         ovf_q <= 1'b1;
            else if (flag_we && reg_wdata_i[0]) ovf_q <= 1'b0;
            if (match)                        cmf_q <= 1'b1;
            else if (flag_we && reg_wdata_i[1]) cmf_q <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_COUNT: reg_rdata_o = cnt_q;
            ADDR_CMP:   reg_rdata_o = cmp_host;
            ADDR_CTRL:  reg_rdata_o[CTRL_W-1:0] = ctrl_q;
            default:    reg_rdata_o[1:0] = {cmf_q, ovf_q};
        endcase
    end

    tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .psel(cur_psel), .tick(tick)
    );

    tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(cur_mode),
        .cnt_we(cnt_we), .cnt_wdata(reg_wdata_i), .cmp_val(cmp_active),
        .cnt_q(cnt_q), .match_o(match), .wrap_o(wrap)
    );

    tmr8_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .mode(cur_mode), .wrap(wrap),
        .host_we(cmp_we), .host_wdata(reg_wdata_i),
        .host_q(cmp_host), .active_q(cmp_active)
    );

    tmr8_wave_unit u_wave (
        .clk(clk), .rst_n(rst_n), .mode(cur_mode), .act(cur_act),
        .match(match), .wrap(wrap), .drive_en(drive_en),
        .level_q(level_q), .pin_o(wave_o)
    );

    assign wave_oe_o  = drive_en;
    assign ovf_flag_o = ovf_q;
    assign cmp_flag_o = cmf_q;

endmodule

// File: rtl/tmr8_wavegen_chk.sv
// Checker for tmr8_wavegen. Relates the port-level register traffic to
// the count, flags and waveform level, and is attached through bind.
module tmr8_wavegen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_i,
    input logic [1:0]       reg_addr_i,
    input logic [CNT_W-1:0] reg_wdata_i,
    input logic             wave_o,
    input logic             wave_oe_o,
    input logic             ovf_flag_o,
    input logic             cmp_flag_o,
    input logic             tick,
    input logic [2:0]       psel,
    input logic [1:0]       mode,
    input logic [1:0]       act,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_act,
    input logic             level_q
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic cnt_wr, ctrl_wr, adv;
    assign cnt_wr  = reg_wr_i && reg_addr_i == 2'd0;
    assign ctrl_wr = reg_wr_i && reg_addr_i == 2'd2;
    assign adv     = tick && !cnt_wr;

    p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((psel == 3'd0 || psel > 3'd5) && !cnt_wr) |=> $stable(cnt_q));

    p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q == CMAX) |=> ovf_flag_o);

    p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q == cmp_act) |=> cmp_flag_o);

    p_host_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(reg_wdata_i)));

    p_ctc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && adv && cnt_q == cmp_act) |=> (cnt_q == '0));

    p_fpwm_bottom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && act == 2'd2 && !ctrl_wr && adv && cnt_q == CMAX) |=> level_q);

    p_pin_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_oe_o |-> !wave_o);

endmodule

bind tmr8_wavegen tmr8_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .wave_o(wave_o), .wave_oe_o(wave_oe_o),
    .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o), .tick(tick),
    .psel(cur_psel), .mode(cur_mode), .act(cur_act), .cnt_q(cnt_q),
    .cmp_act(cmp_active), .level_q(level_q)
);

// File: tb/tb_tmr8_wavegen.sv
module tb_tmr8_wavegen;
    localparam int CNT_W = 8;
    localparam int WD_CYCLES = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr_i = 1'b0;
    logic [1:0]       reg_addr_i = '0;
    logic [CNT_W-1:0] reg_wdata_i = '0;
    logic [CNT_W-1:0] reg_rdata_o;
    logic             wave_o, wave_oe_o, ovf_flag_o, cmp_flag_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    tmr8_wavegen #(.CNT_W(CNT_W), .PRE_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .wave_o(wave_o),
        .wave_oe_o(wave_oe_o), .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o)
    );

    // Vector: {we, waddr, wdata, idle, raddr, expected, req}
    localparam int NV = 23;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 2'd1, 8'h80, 12'd0,   2'd1, 8'h80, 4'd1},  // R1 compare readback
        {1'b1, 2'd2, 8'h01, 12'd0,   2'd2, 8'h01, 4'd1},  // R1 control readback
        {1'b1, 2'd0, 8'h10, 12'd5,   2'd0, 8'h15, 4'd3},  // R3 counting
        {1'b1, 2'd3, 8'h03, 12'd0,   2'd3, 8'h00, 4'd4},  // R4 clear
        {1'b1, 2'd0, 8'hFE, 12'd3,   2'd3, 8'h01, 4'd4},  // R4 wrap sets flag
        {1'b1, 2'd3, 8'h01, 12'd0,   2'd3, 8'h00, 4'd4},  // R4 write-one clear
        {1'b1, 2'd0, 8'h7E, 12'd3,   2'd3, 8'h02, 4'd5},  // R5 match flag
        {1'b1, 2'd3, 8'h02, 12'd0,   2'd3, 8'h00, 4'd5},  // R5 clear
        {1'b1, 2'd0, 8'h7F, 12'd1,   2'd0, 8'h80, 4'd6},  // R6 reach compare
        {1'b1, 2'd0, 8'h20, 12'd0,   2'd3, 8'h00, 4'd6},  // R6 write masks match
        {1'b0, 2'd0, 8'h00, 12'd0,   2'd0, 8'h20, 4'd6},  // R6 write value kept
        {1'b1, 2'd1, 8'h05, 12'd0,   2'd1, 8'h05, 4'd7},  // R7 compare 5
        {1'b1, 2'd2, 8'hA9, 12'd0,   2'd2, 8'hA9, 4'd1},  // R1 CTC, toggle, drive
        {1'b1, 2'd0, 8'h00, 12'd6,   2'd0, 8'h00, 4'd7},  // R7 clear at match
        {1'b0, 2'd0, 8'h00, 12'd0,   2'd3, 8'h02, 4'd7},  // R7 match, no wrap
        {1'b1, 2'd3, 8'h03, 12'd0,   2'd3, 8'h00, 4'd4},  // R4 clear both
        {1'b1, 2'd0, 8'h10, 12'd240, 2'd3, 8'h01, 4'd7},  // R7 above compare: wraps
        {1'b0, 2'd0, 8'h00, 12'd6,   2'd3, 8'h03, 4'd7},  // R7 then matches
        {1'b0, 2'd0, 8'h00, 12'd0,   2'd0, 8'h00, 4'd7},  // R7 cleared
        {1'b1, 2'd0, 8'h40, 12'd0,   2'd0, 8'h40, 4'd7},  // R7 count 0x40
        {1'b1, 2'd1, 8'h03, 12'd0,   2'd1, 8'h03, 4'd7},  // R7 stale-lower compare
        {1'b1, 2'd3, 8'h03, 12'd190, 2'd3, 8'h01, 4'd7},  // R7 missed, wraps
        {1'b0, 2'd0, 8'h00, 12'd4,   2'd3, 8'h03, 4'd7}   // R7 match after wrap
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr_i = a;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wave_o) hi++;
        end
    endtask

    task automatic count_toggles(input int n, output int tg);
        logic prev;
        tg = 0;
        prev = wave_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wave_o != prev) tg++;
            prev = wave_o;
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R11)
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset value", v, 0);
        end
        check("R11 reset pin", wave_o, 0);
        check("R11 reset drive enable", wave_oe_o, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) wr(VEC[i][35:34], VEC[i][33:26]);
            idle(int'(VEC[i][25:14]));
            rd(VEC[i][13:12], v);
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
        end

        // R8: CTC toggle with compare 0 flips every clock
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        count_toggles(24, r);
        check("R8 compare 0 toggles each clock", r, 24);

        // R8 and R7: compare 5 gives a period of 6 advances per toggle
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h00);
        count_toggles(24, r);
        check("R8 toggle every 6 clocks", r, 4);

        // R8: clear action drives the level low
        wr(2'd2, 8'hC9);
        idle(10);
        check("R8 clear action", wave_o, 0);

        // R11: set action with the driver off, then the driver on
        wr(2'd2, 8'h69);
        idle(10);
        check("R11 pin gated off", wave_o, 0);
        check("R11 drive enable low", wave_oe_o, 0);
        wr(2'd2, 8'hE9);
        rd(2'd0, v);
        check("R11 kept level appears", wave_o, 1);
        check("R11 drive enable high", wave_oe_o, 1);

        // R9: fast PWM non-inverting, compare 0x40
        wr(2'd1, 8'h40);
        wr(2'd2, 8'hD1);
        idle(300);
        count_high(256, r);
        check("R9 non-inverting duty", r, 65);

        // R9: inverting
        wr(2'd2, 8'hF1);
        idle(300);
        count_high(256, r);
        check("R9 inverting duty", r, 191);

        // R9 and R10: compare 0xFF stays high
        wr(2'd2, 8'hD1);
        wr(2'd1, 8'hFF);
        idle(300);
        count_high(256, r);
        check("R9 compare max constant high", r, 256);

        // R10: mid-period compare change waits for the wrap
        wr(2'd1, 8'h40);
        idle(300);
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h80);
        rd(2'd1, v);
        check("R10 compare reads back at once", v, 8'h80);
        idle(8'h60 - 8'h11);
        rd(2'd0, v);
        check("R10 count position", v, 8'h60);
        check("R10 old compare governs this period", wave_o, 0);
        idle(256);
        check("R10 new compare governs next period", wave_o, 1);

        // R11: toggle action in fast PWM is disconnected
        wr(2'd2, 8'hB1);
        idle(300);
        count_high(256, r);
        check("R11 fast PWM toggle disconnected", r, 0);

        // R2: prescale factors
        wr(2'd2, 8'h02); wr(2'd0, 8'h00); idle(64);
        rd(2'd0, v); check("R2 divide by 8", v, 8);
        wr(2'd2, 8'h03); wr(2'd0, 8'h00); idle(512);
        rd(2'd0, v); check("R2 divide by 64", v, 8);
        wr(2'd2, 8'h04); wr(2'd0, 8'h00); idle(1024);
        rd(2'd0, v); check("R2 divide by 256", v, 4);
        wr(2'd2, 8'h05); wr(2'd0, 8'h00); idle(2048);
        rd(2'd0, v); check("R2 divide by 1024", v, 2);
        wr(2'd2, 8'h00); wr(2'd0, 8'h33); idle(100);
        rd(2'd0, v); check("R2 select 0 halts", v, 8'h33);
        wr(2'd2, 8'h06); idle(100);
        rd(2'd0, v); check("R2 select 6 halts", v, 8'h33);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule